// File: doc/BRIEF.md
# Shift and Normalize Unit

This block moves a 32-bit operand by a programmable number of bit positions, or normalizes it. Software writes the operand one byte at a time, least significant byte first, and then writes an 8-bit control word. The control word chooses the direction and whether bits leaving one end re-enter at the other. It also chooses whether a separately written carry bit joins the operation, and it gives a 5-bit count. Normalize mode is a reserved control value. In that mode the unit shifts the operand left until its top bit is set, and then writes the number of positions moved into the count field, where it serves as a 5-bit exponent beside the 32-bit mantissa.

Every operation keeps the unit busy for a fixed 36 cycles. The result, the carry and the control word change only in the cycle in which busy drops. While busy, all writes are dropped. The result is read back one byte at a time through a read pointer that returns to byte 0 when an operation completes.

The sequencer has four states. S_IDLE waits for a start. S_SHIFT moves one bit per cycle until the programmed count is reached. S_NORM moves left one bit per cycle while the top bit is clear and fewer than 31 moves have been made. S_HOLD pads out to the fixed latency and commits the result. The transitions are: S_IDLE to S_SHIFT on a start with a nonzero count; S_IDLE to S_NORM on a start with the normalize code; S_IDLE to S_HOLD on a start with count zero; S_SHIFT to S_HOLD when the last bit moves; S_NORM to S_HOLD when the top bit is set or 31 moves are done; S_HOLD to S_IDLE at the 36th busy cycle.

Top module: `shift_norm_unit`

## Requirements
- R1: After reset, busy is 0, and the result bytes, the control word and the carry all read as 0.
- R2: A write to address 0 stores the byte at the load pointer (byte 0 first) and advances the pointer. A fifth write wraps to byte 0 and counts as the first of a new set. A write to address 1 always stores the control word, but it starts an operation only when exactly four bytes have been loaded since the last start. Starting clears the load count.
- R3: busy is high for exactly 36 cycles, starting the cycle after the starting control write. Result, carry and control change only on the edge where busy drops.
- R4: Control bit 7 selects left (1) or right (0). Bits 4:0 give the count. With bits 6 and 5 both clear, vacated positions fill with 0.
- R5: With bit 6 set and bit 5 clear, the operand rotates within 32 bits.
- R6: With bit 5 set and bit 6 clear, vacated positions fill with the carry value held at start, and the carry ends as the last bit shifted out. A count of 0 (not the normalize code) leaves both the operand and the carry unchanged.
- R7: With bits 6 and 5 both set, the carry (address 2, bit 0) and the operand form a 33-bit rotate ring.
- R8: Control value 0x80 selects normalize. The operand shifts left with 0 fill until bit 31 is 1, and bits 4:0 of the control word then hold the number of shifts. An operand whose bit 31 is already set gives exponent 0. The carry is unchanged.
- R9: Normalizing a zero operand stops after 31 shifts, giving result 0 and exponent 31.
- R10: Writes to any address while busy have no effect on the operand, the load count, the control word or the carry.
- R11: Reading address 0 returns the result byte at the read pointer and advances it (LSB first, wrapping after 4). Completion resets the pointer to byte 0. Address 1 returns the control word, address 2 returns {7'b0, carry}, and address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (advances the result pointer at address 0) |
| addr | input | 2 | 0 operand/result, 1 control, 2 carry, 3 unused |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| busy | output | 1 | High while an operation is in progress |

## Verification
A start write sampled on clock edge E0 raises busy after E0, and busy falls after edge E36. Result, carry and exponent become visible in that same cycle. The bench keeps a reference model that advances on every rising edge from the sampled strobes. On each cycle, midway through the low phase, it compares busy and the addressed read data against that model. Directed checks then measure the busy length, and they read the result, control and carry only after busy has dropped. The one exception is the writes issued during busy, which test that they are ignored.

// File: rtl/snu_pkg.sv
package snu_pkg;
    localparam int CNT_W = 5;

    typedef struct packed {
        logic             left;
        logic             circ;
        logic             cen;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SHIFT = 2'd1,
        S_NORM  = 2'd2,
        S_HOLD  = 2'd3
    } state_t;

    localparam logic [1:0] A_DATA  = 2'd0;
    localparam logic [1:0] A_CTRL  = 2'd1;
    localparam logic [1:0] A_CARRY = 2'd2;
    localparam logic [7:0] NORM_CODE = 8'h80;
endpackage

// File: rtl/snu_loader.sv
module snu_loader #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_we,
    input  logic              clr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [DATA_W-1:0] operand,
    output logic              full
);
    localparam int NBYTES = DATA_W / BYTE_W;
    localparam int PTR_W  = $clog2(NBYTES);

    logic [PTR_W-1:0] ptr;
    logic [PTR_W:0]   cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            operand <= '0;
            ptr     <= '0;
            cnt     <= '0;
        end else if (clr) begin
            ptr <= '0;
            cnt <= '0;
        end else if (byte_we) begin
            operand[ptr*BYTE_W +: BYTE_W] <= wdata;
            ptr <= (ptr == PTR_W'(NBYTES-1)) ? '0 : ptr + 1'b1;
            cnt <= (cnt == (PTR_W+1)'(NBYTES)) ? (PTR_W+1)'(1) : cnt + 1'b1;
        end
    end

    assign full = (cnt == (PTR_W+1)'(NBYTES));
endmodule

// File: rtl/snu_step.sv
module snu_step #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] w_in,
    input  logic              c_in,
    input  logic              fill,
    input  logic              left,
    input  logic              circ,
    input  logic              cen,
    output logic [DATA_W-1:0] w_out,
    output logic              c_out
);
    logic out_bit;
    logic in_bit;

    always_comb begin
        out_bit = left ? w_in[DATA_W-1] : w_in[0];
        if (circ) in_bit = cen ? c_in : out_bit;
        else      in_bit = cen ? fill : 1'b0;
        w_out = left ? {w_in[DATA_W-2:0], in_bit} : {in_bit, w_in[DATA_W-1:1]};
        c_out = cen ? out_bit : c_in;
    end
endmodule

// File: rtl/snu_fsm.sv
module snu_fsm
    import snu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int LATENCY = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        start_word,
    input  logic [DATA_W-1:0] operand,
    input  logic              carry_in,
    output logic              busy,
    output logic              done,
    output logic              is_norm,
    output logic [DATA_W-1:0] res,
    output logic              res_carry,
    output logic [CNT_W-1:0]  res_exp
);
    localparam int CYC_W = $clog2(LATENCY);
    localparam logic [CNT_W-1:0] MAX_STEPS = '1;
    localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(LATENCY - 1);

    state_t           state, state_n;
    ctrl_t            sw_c, mc;
    logic [CYC_W-1:0] cyc;
    logic [CNT_W-1:0] steps;
    logic [DATA_W-1:0] wreg, sh_w;
    logic             wc, sh_c, fill, norm_q, do_step;

    assign sw_c = ctrl_t'(start_word);

    snu_step #(.DATA_W(DATA_W)) u_step (
        .w_in (wreg), .c_in (wc), .fill (fill),
        .left (mc.left), .circ (mc.circ), .cen (mc.cen),
        .w_out(sh_w), .c_out(sh_c)
    );

    always_comb begin
        state_n = state;
        done    = 1'b0;
        do_step = 1'b0;
        unique case (state)
            S_IDLE: if (start) begin
                if (start_word == NORM_CODE)  state_n = S_NORM;
                else if (sw_c.cnt == '0)      state_n = S_HOLD;
                else                          state_n = S_SHIFT;
            end
            S_SHIFT: begin
                do_step = 1'b1;
                if (steps + 1'b1 == mc.cnt) state_n = S_HOLD;
            end
            S_NORM: begin
                if (wreg[DATA_W-1] || steps == MAX_STEPS) state_n = S_HOLD;
                else                                      do_step = 1'b1;
            end
            S_HOLD: if (cyc == LAST_CYC) begin
                done    = 1'b1;
                state_n = S_IDLE;
            end
            default: state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc <= '0; steps <= '0; wreg <= '0; wc <= 1'b0;
            fill <= 1'b0; mc <= '0; norm_q <= 1'b0;
        end else if (state == S_IDLE) begin
            if (start) begin
                wreg   <= operand;
                wc     <= carry_in;
                fill   <= carry_in;
                mc     <= sw_c;
                norm_q <= (start_word == NORM_CODE);
                steps  <= '0;
                cyc    <= '0;
            end
        end else begin
            cyc <= cyc + 1'b1;
            if (do_step) begin
                wreg  <= sh_w;
                wc    <= sh_c;
                steps <= steps + 1'b1;
            end
        end
    end

    assign busy      = (state != S_IDLE);
    assign is_norm   = norm_q;
    assign res       = wreg;
    assign res_carry = wc;
    assign res_exp   = steps;

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(cyc) == LAST_CYC);                              // R3
    AST_NORM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && norm_q) |-> (wreg[DATA_W-1] || (wreg == '0 && steps == MAX_STEPS))); // R8
    AST_SHIFT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !norm_q) |-> steps == mc.cnt);                               // R4
endmodule

// File: rtl/shift_norm_unit.sv
module shift_norm_unit
    import snu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int BYTE_W  = 8,
    parameter int LATENCY = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              busy
);
    localparam int NBYTES = DATA_W / BYTE_W;
    localparam int PTR_W  = $clog2(NBYTES);

    logic [DATA_W-1:0] operand, res, result_q;
    logic [CNT_W-1:0]  res_exp;
    logic [BYTE_W-1:0] ctrl_q;
    logic [PTR_W-1:0]  rptr;
    logic full, done, is_norm, res_carry, carry_q;
    logic wr_ok, byte_we, ctrl_we, carry_we, start;

    assign wr_ok    = wr_en && !busy;
    assign byte_we  = wr_ok && (addr == A_DATA);
    assign ctrl_we  = wr_ok && (addr == A_CTRL);
    assign carry_we = wr_ok && (addr == A_CARRY);
    assign start    = ctrl_we && full;

    snu_loader #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_load (
        .clk(clk), .rst_n(rst_n), .byte_we(byte_we), .clr(start),
        .wdata(wdata), .operand(operand), .full(full)
    );

    snu_fsm #(.DATA_W(DATA_W), .LATENCY(LATENCY)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .start_word(wdata),
        .operand(operand), .carry_in(carry_q), .busy(busy), .done(done),
        .is_norm(is_norm), .res(res), .res_carry(res_carry), .res_exp(res_exp)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            ctrl_q   <= '0;
            carry_q  <= 1'b0;
        end else if (done) begin
            result_q <= res;
            carry_q  <= res_carry;
            if (is_norm) ctrl_q[CNT_W-1:0] <= res_exp;
        end else begin
            if (ctrl_we)  ctrl_q  <= wdata;
            if (carry_we) carry_q <= wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        rptr <= '0;
        else if (done)                     rptr <= '0;
        else if (rd_en && addr == A_DATA)  rptr <= rptr + 1'b1;
    end

    always_comb begin
        unique case (addr)
            A_DATA:  rdata = result_q[rptr*BYTE_W +: BYTE_W];
            A_CTRL:  rdata = ctrl_q;
            A_CARRY: rdata = {{(BYTE_W-1){1'b0}}, carry_q};
            default: rdata = '0;
        endcase
    end

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(result_q));                         // R3
    AST_BUSY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && wr_en) |=> ($stable(operand) && $stable(ctrl_q) && $stable(carry_q))); // R10
    AST_START_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(full));                                         // R2
endmodule

// File: tb/shift_norm_unit_tb.sv
module shift_norm_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       busy;

    int compared = 0;
    int mismatched = 0;

    always #10 clk = ~clk;

    shift_norm_unit u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
    );

    // reference model state
    int          m_left;
    logic [7:0]  m_bytes [4];
    int          m_ptr, m_cnt, m_rptr;
    logic [7:0]  m_ctrl, p_ctrl;
    logic        m_carry, p_carry;
    logic [31:0] m_result, p_res;

    function automatic void model_op(input logic [31:0] w, input logic [7:0] c, input logic cy,
                                     output logic [31:0] r, output logic [7:0] oc, output logic ocy);
        int n;
        logic [32:0] ring;
        logic [63:0] mask;
        n = int'(c[4:0]);
        oc = c; ocy = cy; r = w;
        if (c == 8'h80) begin
            int e = 0;
            while (r[31] == 1'b0 && e < 31) begin r = r << 1; e++; end
            oc = {3'b100, 5'(e)};
        end else if (c[6] && c[5]) begin
            ring = {cy, w};
            if (c[7]) ring = (ring << n) | (ring >> (33 - n));
            else      ring = (ring >> n) | (ring << (33 - n));
            r = ring[31:0]; ocy = ring[32];
        end else if (c[6]) begin
            if (c[7]) r = (w << n) | (w >> (32 - n));
            else      r = (w >> n) | (w << (32 - n));
        end else begin
            mask = (64'd1 << n) - 64'd1;
            if (c[7]) begin
                r = w << n;
                if (c[5] && cy) r = r | mask[31:0];
                if (c[5] && n > 0) ocy = w[32 - n];
            end else begin
                r = w >> n;
                if (c[5] && cy) r = r | ~(32'hFFFF_FFFF >> n);
                if (c[5] && n > 0) ocy = w[n - 1];
            end
        end
    endfunction

    function automatic logic [7:0] model_rdata(input logic [1:0] a);
        case (a)
            2'd0:    return m_result[m_rptr*8 +: 8];
            2'd1:    return m_ctrl;
            2'd2:    return {7'b0, m_carry};
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_left = 0; m_ptr = 0; m_cnt = 0; m_rptr = 0;
            m_ctrl = 8'h00; m_carry = 1'b0; m_result = 32'h0;
            for (int i = 0; i < 4; i++) m_bytes[i] = 8'h00;
        end else if (m_left > 0) begin
            m_left--;
            if (m_left == 0) begin
                m_result = p_res; m_ctrl = p_ctrl; m_carry = p_carry; m_rptr = 0;
            end else if (rd_en && addr == 2'd0) m_rptr = (m_rptr + 1) % 4;
        end else begin
            if (rd_en && addr == 2'd0) m_rptr = (m_rptr + 1) % 4;
            if (wr_en) begin
                case (addr)
                    2'd0: begin
                        m_bytes[m_ptr] = wdata;
                        m_ptr = (m_ptr + 1) % 4;
                        m_cnt = (m_cnt == 4) ? 1 : m_cnt + 1;
                    end
                    2'd1: begin
                        m_ctrl = wdata;
                        if (m_cnt == 4) begin
                            model_op({m_bytes[3], m_bytes[2], m_bytes[1], m_bytes[0]},
                                     wdata, m_carry, p_res, p_ctrl, p_carry);
                            m_left = 36; m_cnt = 0; m_ptr = 0;
                        end
                    end
                    2'd2: m_carry = wdata[0];
                    default: ;
                endcase
            end
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        #5;
        if (rst_n) begin
            compared += 2;
            if (busy !== (m_left > 0)) begin
                mismatched++;
                $display("FAIL R3 busy per-cycle actual=%0b expected=%0b", busy, (m_left > 0));
            end
            if (rdata !== model_rdata(addr)) begin
                mismatched++;
                $display("FAIL R11 rdata per-cycle addr=%0d actual=%h expected=%h", addr, rdata, model_rdata(addr));
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 2'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; addr = 2'd0;
    endtask

    task automatic load(input logic [31:0] v);
        for (int i = 0; i < 4; i++) wr(2'd0, v[i*8 +: 8]);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 100) begin n++; @(negedge clk); end
    endtask

    task automatic read32(output logic [31:0] v);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin rd(2'd0, b); v[i*8 +: 8] = b; end
    endtask

    task automatic run(input string tag, input logic [31:0] op, input logic [7:0] c,
                       input logic [31:0] exp);
        int n;
        logic [31:0] v;
        load(op);
        wr(2'd1, c);
        wait_idle(n);
        chk("R3 busy length", 32'(n), 32'd36);
        read32(v);
        chk(tag, v, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL R3 watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [31:0] v;
        int          n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", 32'(busy), 32'd0);
        rd(2'd1, b); chk("R1 ctrl", 32'(b), 32'h0);
        rd(2'd2, b); chk("R1 carry", 32'(b), 32'h0);
        rd(2'd0, b); chk("R1 result byte", 32'(b), 32'h0);

        // R2 short load does not start; control still stored
        wr(2'd0, 8'h78); wr(2'd0, 8'h56); wr(2'd0, 8'h34);
        wr(2'd1, 8'h84);
        chk("R2 no start with 3 bytes", 32'(busy), 32'd0);
        rd(2'd1, b); chk("R2 ctrl stored", 32'(b), 32'h84);
        wr(2'd0, 8'h12);
        wr(2'd1, 8'h84);
        chk("R2 start with 4 bytes", 32'(busy), 32'd1);
        wait_idle(n);
        chk("R3 busy length", 32'(n), 32'd36);
        read32(v); chk("R4 left 4", v, 32'h2345_6780);
        rd(2'd0, b); chk("R11 pointer wraps", 32'(b), 32'h80);
        rd(2'd3, b); chk("R11 unused addr", 32'(b), 32'h0);

        run("R4 right 8", 32'h1234_5678, 8'h08, 32'h0012_3456);
        run("R5 rotate right 8", 32'h1234_5678, 8'h48, 32'h7812_3456);
        run("R5 rotate left 31", 32'h1234_5678, 8'hDF, 32'h091A_2B3C);

        // R6 carry fill
        wr(2'd2, 8'h01);
        run("R6 left fill carry", 32'h8000_0001, 8'hA4, 32'h0000_001F);
        rd(2'd2, b); chk("R6 carry last out", 32'(b), 32'h0);
        run("R6 right fill carry0", 32'h0000_0010, 8'h25, 32'h0000_0000);
        rd(2'd2, b); chk("R6 carry last out right", 32'(b), 32'h1);
        run("R6 count zero", 32'hA5A5_A5A5, 8'h20, 32'hA5A5_A5A5);
        rd(2'd2, b); chk("R6 count zero carry kept", 32'(b), 32'h1);

        // R7 33-bit ring
        wr(2'd2, 8'h00);
        run("R7 ring left 1", 32'h8000_0000, 8'hE1, 32'h0000_0000);
        rd(2'd2, b); chk("R7 carry from msb", 32'(b), 32'h1);
        wr(2'd2, 8'h00);
        run("R7 ring right 1", 32'h0000_0001, 8'h61, 32'h0000_0000);
        rd(2'd2, b); chk("R7 carry from lsb", 32'(b), 32'h1);

        // R8 normalize
        run("R8 normalize", 32'h0001_2345, 8'h80, 32'h91A2_8000);
        rd(2'd1, b); chk("R8 exponent 15", 32'(b), 32'h8F);
        rd(2'd2, b); chk("R8 carry unchanged", 32'(b), 32'h1);
        run("R8 already normal", 32'h8000_0000, 8'h80, 32'h8000_0000);
        rd(2'd1, b); chk("R8 exponent 0", 32'(b), 32'h80);

        // R9 zero and single-bit normalize
        run("R9 zero result", 32'h0000_0000, 8'h80, 32'h0000_0000);
        rd(2'd1, b); chk("R9 zero exponent 31", 32'(b), 32'h9F);
        run("R9 lsb only", 32'h0000_0001, 8'h80, 32'h8000_0000);
        rd(2'd1, b); chk("R9 lsb exponent 31", 32'(b), 32'h9F);

        // R2 fifth write wraps to byte 0
        load(32'h4433_2211); wr(2'd0, 8'h55);
        wr(2'd1, 8'h80);
        chk("R2 fifth write no start", 32'(busy), 32'd0);
        wr(2'd0, 8'h66); wr(2'd0, 8'h77); wr(2'd0, 8'h88);
        wr(2'd1, 8'h80);
        wait_idle(n);
        read32(v); chk("R2 wrapped operand", v, 32'h8877_6655);

        // R10 writes while busy ignored
        wr(2'd2, 8'h00);
        load(32'h1234_5678);
        wr(2'd1, 8'h84);
        wr(2'd0, 8'hFF); wr(2'd1, 8'h00); wr(2'd2, 8'h01);
        wait_idle(n);
        rd(2'd1, b); chk("R10 ctrl kept", 32'(b), 32'h84);
        rd(2'd2, b); chk("R10 carry kept", 32'(b), 32'h0);
        load(32'h1234_5678);
        wr(2'd1, 8'h88);
        chk("R10 load count kept", 32'(busy), 32'd1);
        wait_idle(n);
        read32(v); chk("R10 operand kept", v, 32'h3456_7800);

        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule